// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block decides when a display and keypad driver sleeps and when it wakes. Software writes two sleep control bits. If either bit is set, the block is asleep. In that state it blanks the segment and common drivers, stops the display oscillator and raises a sleep-acknowledge status for the serial readout. The block wakes only when software clears both bits.

A key press restarts the oscillator while sleep is still commanded, so that the key scan can run. The key input arrives asynchronously and passes through a synchroniser before it takes effect. The oscillator stays on until two things are true: the synchronised key input is low, and the key scan reports that no key is held. If a sleep bit is still set at that point, the oscillator is gated off again. The drivers stay blanked and the acknowledge stays high for the whole time the oscillator is running after a key press.

Two shared pins can serve as general-purpose outputs. They follow their own control bits in every mode and are never blanked by sleep. Reset clears all control bits, so the block starts awake with both port pins low.

Top module: `sleep_pwr_ctrl`

## Requirements
- R1: After reset, `osc_en_o`=1, `drv_blank_o`=0, `sleep_ack_o`=0 and `port_o`=0.
- R2: A write on `sleep_we_i` with any bit of `sleep_bits_i` set makes `sleep_ack_o` and `drv_blank_o` 1 from the next clock cycle.
- R3: The block leaves sleep only after a write with `sleep_bits_i`=0. A write that leaves one bit set keeps the block asleep, and without a write the sleep state holds.
- R4: When asleep and not woken by a key, `osc_en_o` is 0. When awake, `osc_en_o` is always 1.
- R5: While asleep, holding `key_async_i` high makes `osc_en_o` 1 after SYNC_STAGES+1 rising clock edges (3 with the default of 2).
- R6: After a key wake, `osc_en_o` stays 1 until the synchronised key is low and `key_held_i` is 0 at the same clock edge. It then returns to 0 if sleep is still commanded.
- R7: During a key wake, `drv_blank_o` and `sleep_ack_o` remain 1.
- R8: A write on `port_we_i` makes `port_o` equal to the written `port_bits_i` from the next cycle, in every mode. Bit i of `port_o` drives shared pin i.
- R9: A key press that starts and ends while the block is awake leaves no pending wake. A later entry into sleep turns the oscillator off.
- R10: A sleep-bit write does not change `port_o`, and a port write does not change the sleep state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on control clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_we_i | input | 1 | Write strobe for the sleep control bits |
| sleep_bits_i | input | 2 | Sleep control bits to write |
| port_we_i | input | 1 | Write strobe for the port control bits |
| port_bits_i | input | NUM_PORTS | Port control bits to write |
| key_async_i | input | 1 | Asynchronous key-pressed indication |
| key_held_i | input | 1 | Key scan reports a key held |
| osc_en_o | output | 1 | Display oscillator enable |
| drv_blank_o | output | 1 | Force segment and common drivers low |
| sleep_ack_o | output | 1 | Sleep acknowledge status for readout |
| port_o | output | NUM_PORTS | General-purpose port pin values |

## Verification
The hardest situation to reach from the ports is the end of a key wake. The synchronised key must fall while the key scan still reports a held key, and only later must the held report drop, all while a sleep bit remains set. The stimulus enters sleep and holds the key for several cycles. It then releases the key with `key_held_i` still high and lowers `key_held_i` a few cycles later. A second sequence enters sleep while a key is already down, which catches the one-cycle gap before the synchroniser output reaches the wake logic.

// File: rtl/sleep_pwr_pkg.sv
package sleep_pwr_pkg;
  localparam int unsigned SLEEP_BITS = 2;

  typedef struct packed {
    logic osc_en;
    logic blank;
    logic ack;
  } pwr_out_t;
endpackage

// File: rtl/sleep_key_sync.sv
module sleep_key_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/sleep_ctrl_regs.sv
module sleep_ctrl_regs
  import sleep_pwr_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sleep_we_i,
  input  logic [SLEEP_BITS-1:0] sleep_bits_i,
  input  logic                  port_we_i,
  input  logic [NUM_PORTS-1:0]  port_bits_i,
  output logic                  sleep_o,
  output logic [NUM_PORTS-1:0]  port_o
);
  logic [SLEEP_BITS-1:0] sleep_q;
  logic [NUM_PORTS-1:0]  port_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         sleep_q <= '0;
    else if (sleep_we_i) sleep_q <= sleep_bits_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        port_q <= '0;
    else if (port_we_i) port_q <= port_bits_i;

  // any set bit commands sleep
  assign sleep_o = |sleep_q;
  assign port_o  = port_q;
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import sleep_pwr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sleep_i,
  input  logic     key_sync_i,
  input  logic     key_held_i,
  output pwr_out_t pwr_o
);
  logic woke_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                       woke_q <= 1'b0;
    else if (!sleep_i)                 woke_q <= 1'b0;
    else if (key_sync_i)               woke_q <= 1'b1;
    else if (!key_held_i)              woke_q <= 1'b0;

  always_comb begin
    pwr_o.osc_en = !sleep_i || woke_q;
    pwr_o.blank  = sleep_i;
    pwr_o.ack    = sleep_i;
  end
endmodule

// File: rtl/sleep_pwr_ctrl.sv
module sleep_pwr_ctrl
  import sleep_pwr_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sleep_we_i,
  input  logic [1:0]            sleep_bits_i,
  input  logic                  port_we_i,
  input  logic [NUM_PORTS-1:0]  port_bits_i,
  input  logic                  key_async_i,
  input  logic                  key_held_i,
  output logic                  osc_en_o,
  output logic                  drv_blank_o,
  output logic                  sleep_ack_o,
  output logic [NUM_PORTS-1:0]  port_o
);
  logic     sleep;
  logic     key_sync;
  pwr_out_t pwr;

  sleep_ctrl_regs #(.NUM_PORTS(NUM_PORTS)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_we_i   (sleep_we_i),
    .sleep_bits_i (sleep_bits_i),
    .port_we_i    (port_we_i),
    .port_bits_i  (port_bits_i),
    .sleep_o      (sleep),
    .port_o       (port_o)
  );

  sleep_key_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (key_async_i),
    .q_o    (key_sync)
  );

  sleep_wake_ctrl i_wake (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_i    (sleep),
    .key_sync_i (key_sync),
    .key_held_i (key_held_i),
    .pwr_o      (pwr)
  );

  assign osc_en_o    = pwr.osc_en;
  assign drv_blank_o = pwr.blank;
  assign sleep_ack_o = pwr.ack;
endmodule

// File: rtl/sleep_pwr_ctrl_chk.sv
module sleep_pwr_ctrl_chk #(
  parameter int unsigned NUM_PORTS = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sleep_we_i,
  input logic [1:0]           sleep_bits_i,
  input logic                 port_we_i,
  input logic [NUM_PORTS-1:0] port_bits_i,
  input logic                 key_held_i,
  input logic                 osc_en_o,
  input logic                 drv_blank_o,
  input logic                 sleep_ack_o,
  input logic [NUM_PORTS-1:0] port_o
);
  p_enter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_we_i && (sleep_bits_i != 2'b00) |=> sleep_ack_o && drv_blank_o);

  p_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_we_i && (sleep_bits_i == 2'b00) |=> !sleep_ack_o);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_we_i |=> $stable(sleep_ack_o));

  p_awake_osc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_ack_o |-> osc_en_o);

  p_wake_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) && !$past(sleep_we_i) |-> sleep_ack_o && !$past(key_held_i));

  p_port_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_we_i |=> port_o == $past(port_bits_i));

  p_port_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_we_i |=> $stable(port_o));
endmodule

bind sleep_pwr_ctrl sleep_pwr_ctrl_chk #(.NUM_PORTS(NUM_PORTS)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sleep_we_i   (sleep_we_i),
  .sleep_bits_i (sleep_bits_i),
  .port_we_i    (port_we_i),
  .port_bits_i  (port_bits_i),
  .key_held_i   (key_held_i),
  .osc_en_o     (osc_en_o),
  .drv_blank_o  (drv_blank_o),
  .sleep_ack_o  (sleep_ack_o),
  .port_o       (port_o)
);

// File: tb/test_sleep_pwr_ctrl.sv
`timescale 1ns/1ps
module test_sleep_pwr_ctrl;
  localparam int NP = 2;
  localparam int NS = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sleep_we_i = 1'b0;
  logic [1:0]    sleep_bits_i = '0;
  logic          port_we_i = 1'b0;
  logic [NP-1:0] port_bits_i = '0;
  logic          key_async_i = 1'b0;
  logic          key_held_i = 1'b0;
  logic          osc_en_o, drv_blank_o, sleep_ack_o;
  logic [NP-1:0] port_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  string req = "R1";

  // reference state
  int m_sleep = 0, m_port = 0, m_woke = 0;
  int kq[$];

  always #4 clk_i = ~clk_i;

  sleep_pwr_ctrl #(.NUM_PORTS(NP), .SYNC_STAGES(NS)) i_sleep_pwr_ctrl (
    .clk_i, .rst_ni, .sleep_we_i, .sleep_bits_i, .port_we_i, .port_bits_i,
    .key_async_i, .key_held_i, .osc_en_o, .drv_blank_o, .sleep_ack_o, .port_o
  );

  task automatic chk(string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    int asleep = (m_sleep != 0);
    chk("osc_en", osc_en_o, (!asleep || m_woke) ? 1 : 0);
    chk("blank", drv_blank_o, asleep);
    chk("ack", sleep_ack_o, asleep);
    chk("port", port_o, m_port);
  endtask

  task automatic step();
    int ks, nw, asleep;
    @(posedge clk_i);
    asleep = (m_sleep != 0);
    ks = kq[$];
    if (!asleep) nw = 0;
    else if (ks != 0) nw = 1;
    else if (!key_held_i) nw = 0;
    else nw = m_woke;
    m_woke = nw;
    if (sleep_we_i) m_sleep = sleep_bits_i;
    if (port_we_i) m_port = port_bits_i;
    void'(kq.pop_back());
    kq.push_front(key_async_i);
    @(negedge clk_i);
    compare();
  endtask

  task automatic wr_sleep(int v);
    sleep_we_i = 1'b1; sleep_bits_i = v[1:0];
    step();
    sleep_we_i = 1'b0;
  endtask

  task automatic wr_port(int v);
    port_we_i = 1'b1; port_bits_i = v[NP-1:0];
    step();
    port_we_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 5000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 5000 cycles", cyc);
        finish_run();
      end
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) kq.push_back(0);
    repeat (3) @(negedge clk_i);
    req = "R1";
    compare();
    rst_ni = 1'b1;
    idle(2);

    req = "R8"; wr_port(1); wr_port(2); wr_port(3); idle(1);
    req = "R2"; wr_sleep(1); idle(2);
    req = "R4"; idle(3);
    req = "R8"; wr_port(0); wr_port(2); idle(1);
    req = "R10"; wr_sleep(3); wr_port(1); idle(1);
    req = "R3"; wr_sleep(2); idle(2); wr_sleep(0); idle(2);
    req = "R2"; wr_sleep(2); idle(2);

    // key wake while asleep
    req = "R5"; key_async_i = 1'b1; idle(4);
    req = "R7"; key_held_i = 1'b1; idle(3);
    req = "R6"; key_async_i = 1'b0; idle(4);
    key_held_i = 1'b0; idle(3);
    req = "R4"; idle(2);

    // short key pulse, held report drops together
    req = "R6"; key_async_i = 1'b1; idle(1); key_async_i = 1'b0; idle(6);

    // key pulse while awake leaves no pending wake
    req = "R9"; wr_sleep(0); key_async_i = 1'b1; idle(3);
    key_async_i = 1'b0; idle(3); wr_sleep(1); idle(3);

    // sleep entered while key already down
    req = "R5"; wr_sleep(0); key_async_i = 1'b1; key_held_i = 1'b1; idle(3);
    wr_sleep(1); idle(3);
    req = "R6"; key_async_i = 1'b0; key_held_i = 1'b0; idle(4);
    req = "R3"; wr_sleep(0); idle(2);
    finish_run();
  end
endmodule